// File: doc/BRIEF.md
# DSP Register Transfer Unit

This block carries out the register-to-register move of a small 16-bit signal processor. Each valid instruction word is decoded in one clock. When it belongs to the move group, the unit copies the chosen source register into the chosen destination register. It converts the width whenever a 16-bit register and a 32-bit register meet. The register space has sixteen slots:

- a read-only all-ones constant
- general 16-bit registers
- a 32-bit accumulator, plus a view of its low half
- a 32-bit product register
- the program counter
- a port onto a small hardware return stack

After every instruction the unit reports how many cycles it cost. Any register can be observed at any time through a combinational read port. The top entry of the return stack is also visible on its own output. A surrounding sequencer feeds one instruction per accepted strobe and uses the cost output to pace instruction fetch. Two sticky flags tell it about opcodes the unit does not execute and about misuse of the return stack.

Top module: `regxfer_unit`

## Requirements
- R1: After reset the program counter reads 0x0400, slot 5 reads 5 (empty stack), all other slots except slot 0 read zero, both flags are low and no cost is reported.
- R2: Slot 0 always reads 0x0000FFFF. A move that names slot 0 as destination changes no register.
- R3: An instruction word with bits [15:9] all zero is a move. Its source slot is bits [3:0] and its destination slot is bits [7:4]. A move between two 16-bit slots copies the value.
- R4: When a 32-bit source (slot 3 accumulator, slot 7 product) meets a 16-bit destination, the destination receives bits [31:16] of the source.
- R5: When a 16-bit source meets a 32-bit destination, bits [31:16] of the destination are written and bits [15:0] keep their value.
- R6: A move from a 32-bit slot into a 32-bit slot copies all 32 bits.
- R7: Slot 15 reads and writes bits [15:0] of the accumulator and leaves bits [31:16] untouched.
- R8: The all-zero word changes no register. It only advances the program counter by one and costs one cycle.
- R9: Every accepted instruction reports its cost one clock after the strobe. A move into slot 6 loads the program counter and costs 2 cycles. Every other instruction advances the program counter by one and costs 1 cycle.
- R10: Reading slot 5 pops the return stack and writing slot 5 pushes it. The stack holds 6 entries. Observing slot 5 returns 5 minus the number of entries, modulo 16. The top-of-stack output shows the newest entry, or zero when the stack is empty. A move from slot 5 to slot 5 on a non-empty stack leaves the stack as it was.
- R11: A pop from an empty stack, or a push onto a full one, sets a sticky stack error flag and leaves the stack and all registers unchanged. The program counter still advances by one.
- R12: An instruction word with any of bits [15:9] set raises a sticky unhandled-opcode flag, changes no register except the normal program counter advance, and costs 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word |
| instr_vld_i | input | 1 | Instruction word is valid this cycle |
| obs_sel_i | input | 4 | Slot to observe |
| obs_data_o | output | 32 | Observed slot value, zero-extended for 16-bit slots |
| tos_o | output | 16 | Newest return-stack entry, zero when empty |
| cost_vld_o | output | 1 | Cost of the previous instruction is valid |
| cost_o | output | 2 | Cycle cost of the previous instruction |
| unhandled_o | output | 1 | Sticky flag: an opcode outside the move group was seen |
| stk_err_o | output | 1 | Sticky flag: a stack overflow or underflow was attempted |

## Verification
The bench builds the unit with its defaults: a 16-bit data path, a 6-level stack and a start address of 0x0400. With these values the stack reaches full after six pushes, so both the overflow and the underflow boundary are hit within a few instructions. Directed sequences walk through every width pairing, the slot 15 low-half alias, loading the program counter and both stack limits. After that, seeded random moves copy program-counter and constant values between all sixteen slots, and every slot is compared with a model after each step.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;
    localparam int NREG = 16;

    localparam logic [3:0] SLOT_ONES = 4'd0;
    localparam logic [3:0] SLOT_ACC  = 4'd3;
    localparam logic [3:0] SLOT_STK  = 4'd5;
    localparam logic [3:0] SLOT_PC   = 4'd6;
    localparam logic [3:0] SLOT_PROD = 4'd7;
    localparam logic [3:0] SLOT_ACCL = 4'd15;

    typedef struct packed {
        logic       is_move;
        logic       is_nop;
        logic [3:0] src;
        logic [3:0] dst;
        logic       src_wide;
        logic       dst_wide;
    } dec_t;

    function automatic logic slot_is_wide(logic [3:0] s);
        return (s == SLOT_ACC) || (s == SLOT_PROD);
    endfunction
endpackage

// File: rtl/regxfer_decode.sv
module regxfer_decode
    import regxfer_pkg::*;
(
    input  logic [15:0] op_i,
    output dec_t        dec_o
);
    always_comb begin
        dec_o.is_move  = (op_i[15:9] == 7'd0);
        dec_o.is_nop   = (op_i == 16'd0);
        dec_o.src      = op_i[3:0];
        dec_o.dst      = op_i[7:4];
        dec_o.src_wide = slot_is_wide(op_i[3:0]);
        dec_o.dst_wide = slot_is_wide(op_i[7:4]);
    end
endmodule

// File: rtl/regxfer_stack.sv
module regxfer_stack #(
    parameter int DW    = 16,
    parameter int DEPTH = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [DW-1:0]   data_i,
    input  logic            err_set_i,
    output logic            empty_o,
    output logic            full_o,
    output logic [DW-1:0]   tos_o,
    output logic [$clog2(DEPTH):0] sp_o,
    output logic            err_o
);
    localparam int IW   = $clog2(DEPTH);
    localparam int SP_W = IW + 1;
    localparam logic [SP_W-1:0] SP_EMPTY = SP_W'(DEPTH - 1);
    localparam logic [SP_W-1:0] SP_FULL  = '1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [SP_W-1:0]          sp;
        logic                     err;
    } stk_t;

    stk_t st_d, st_q;
    logic [SP_W-1:0] top_sp;
    logic [IW-1:0]   top_idx;
    logic [IW-1:0]   free_idx;

    always_comb begin
        top_sp   = st_q.sp + SP_W'(1);
        top_idx  = top_sp[IW-1:0];
        free_idx = st_q.sp[IW-1:0];
        empty_o  = (st_q.sp == SP_EMPTY);
        full_o   = (st_q.sp == SP_FULL);
        tos_o    = empty_o ? '0 : st_q.mem[top_idx];
        sp_o     = st_q.sp;
        err_o    = st_q.err;

        st_d = st_q;
        if (err_set_i) st_d.err = 1'b1;
        if (push_i && pop_i) begin
            st_d.mem[top_idx] = data_i;
        end else if (push_i) begin
            st_d.mem[free_idx] = data_i;
            st_d.sp = st_q.sp - SP_W'(1);
        end else if (pop_i) begin
            st_d.sp = top_sp;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.mem <= '0;
            st_q.sp  <= SP_EMPTY;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    sp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.sp <= SP_EMPTY) || (st_q.sp == SP_FULL));
    // R11
    no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i) |-> !full_o);
    // R11
    no_pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i |-> !empty_o);
    // R11
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);
endmodule

// File: rtl/regxfer_unit.sv
module regxfer_unit
    import regxfer_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          STK_DEPTH = 6,
    parameter logic [15:0] RESET_PC  = 16'h0400
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [15:0]   instr_i,
    input  logic          instr_vld_i,
    input  logic [3:0]    obs_sel_i,
    output logic [31:0]   obs_data_o,
    output logic [15:0]   tos_o,
    output logic          cost_vld_o,
    output logic [1:0]    cost_o,
    output logic          unhandled_o,
    output logic          stk_err_o
);
    localparam int AW   = 2 * DW;
    localparam int SP_W = $clog2(STK_DEPTH) + 1;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] gr;
        logic [AW-1:0]           acc;
        logic [AW-1:0]           prod;
        logic [DW-1:0]           pc;
        logic                    cost_vld;
        logic [1:0]              cost;
        logic                    unh;
    } unit_t;

    unit_t st_d, st_q;
    dec_t  dec;

    logic            stk_push, stk_pop, stk_err_set;
    logic            stk_empty, stk_full;
    logic [DW-1:0]   stk_tos;
    logic [SP_W-1:0] stk_sp;
    logic [AW-1:0]   src_val;
    logic [DW-1:0]   narrow;
    logic            blocked;

    regxfer_decode i_decode (
        .op_i  (instr_i),
        .dec_o (dec)
    );

    regxfer_stack #(.DW(DW), .DEPTH(STK_DEPTH)) i_stack (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (stk_push),
        .pop_i     (stk_pop),
        .data_i    (narrow),
        .err_set_i (stk_err_set),
        .empty_o   (stk_empty),
        .full_o    (stk_full),
        .tos_o     (stk_tos),
        .sp_o      (stk_sp),
        .err_o     (stk_err_o)
    );

    // source operand as seen by a move
    always_comb begin
        case (dec.src)
            SLOT_ONES: src_val = AW'({DW{1'b1}});
            SLOT_ACC:  src_val = st_q.acc;
            SLOT_PROD: src_val = st_q.prod;
            SLOT_ACCL: src_val = AW'(st_q.acc[DW-1:0]);
            SLOT_STK:  src_val = AW'(stk_tos);
            SLOT_PC:   src_val = AW'(st_q.pc);
            default:   src_val = AW'(st_q.gr[dec.src]);
        endcase
        narrow = dec.src_wide ? src_val[AW-1:DW] : src_val[DW-1:0];
    end

    // observation port
    always_comb begin
        case (obs_sel_i)
            SLOT_ONES: obs_data_o = 32'(AW'({DW{1'b1}}));
            SLOT_ACC:  obs_data_o = 32'(st_q.acc);
            SLOT_PROD: obs_data_o = 32'(st_q.prod);
            SLOT_ACCL: obs_data_o = 32'(st_q.acc[DW-1:0]);
            SLOT_STK:  obs_data_o = 32'(stk_sp);
            SLOT_PC:   obs_data_o = 32'(st_q.pc);
            default:   obs_data_o = 32'(st_q.gr[obs_sel_i]);
        endcase
    end

    // next state
    always_comb begin
        st_d        = st_q;
        st_d.cost_vld = 1'b0;
        stk_push    = 1'b0;
        stk_pop     = 1'b0;
        stk_err_set = 1'b0;
        blocked     = ((dec.src == SLOT_STK) && stk_empty) ||
                      ((dec.dst == SLOT_STK) && (dec.src != SLOT_STK) && stk_full);
        if (instr_vld_i) begin
            st_d.cost_vld = 1'b1;
            st_d.cost     = 2'd1;
            st_d.pc       = st_q.pc + DW'(1);
            if (!dec.is_move) begin
                st_d.unh = 1'b1;
            end else if (!dec.is_nop) begin
                if (dec.dst == SLOT_PC) st_d.cost = 2'd2;
                if (blocked) begin
                    stk_err_set = 1'b1;
                end else begin
                    stk_pop  = (dec.src == SLOT_STK);
                    stk_push = (dec.dst == SLOT_STK);
                    case (dec.dst)
                        SLOT_ONES, SLOT_STK: ;
                        SLOT_ACC: begin
                            if (dec.src_wide) st_d.acc = src_val;
                            else              st_d.acc[AW-1:DW] = narrow;
                        end
                        SLOT_PROD: begin
                            if (dec.src_wide) st_d.prod = src_val;
                            else              st_d.prod[AW-1:DW] = narrow;
                        end
                        SLOT_ACCL: st_d.acc[DW-1:0] = narrow;
                        SLOT_PC:   st_d.pc = narrow;
                        default:   st_d.gr[dec.dst] = narrow;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.gr       <= '0;
            st_q.acc      <= '0;
            st_q.prod     <= '0;
            st_q.pc       <= RESET_PC;
            st_q.cost_vld <= 1'b0;
            st_q.cost     <= 2'd0;
            st_q.unh      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tos_o       = stk_tos;
    assign cost_vld_o  = st_q.cost_vld;
    assign cost_o      = st_q.cost;
    assign unhandled_o = st_q.unh;

    // R12
    unh_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_vld_i && !dec.is_move) |=>
            ($stable(st_q.acc) && $stable(st_q.prod) && $stable(st_q.gr) &&
             st_q.pc == $past(st_q.pc) + DW'(1) && cost_o == 2'd1));
    // R12
    unh_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unhandled_o |=> unhandled_o);
    // R8
    nop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_vld_i && instr_i == 16'd0) |=>
            ($stable(st_q.acc) && $stable(st_q.prod) && $stable(st_q.gr) &&
             st_q.pc == $past(st_q.pc) + DW'(1)));
    // R9
    pc_cost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_vld_i && dec.is_move && instr_i[7:4] == SLOT_PC) |=>
            (cost_vld_o && cost_o == 2'd2));
    // R9
    cost_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cost_vld_o |-> (cost_o == 2'd1 || cost_o == 2'd2));
    // R11
    blocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_vld_i && dec.is_move && blocked) |=>
            ($stable(st_q.acc) && $stable(st_q.prod) && $stable(st_q.gr) && stk_err_o));
endmodule

// File: tb/test_regxfer_unit.sv
`timescale 1ns/1ps
module test_regxfer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'd0;
    logic        vld = 1'b0;
    logic [3:0]  sel = 4'd0;
    logic [31:0] obs;
    logic [15:0] tos;
    logic        cost_vld;
    logic [1:0]  cost;
    logic        unh;
    logic        serr;

    int total = 0;
    int bad   = 0;

    // model
    logic [15:0] m_gr [16];
    logic [31:0] m_acc, m_prod;
    logic [15:0] m_pc;
    logic [15:0] m_stk [6];
    int          m_lvl;
    logic        m_serr, m_unh;
    logic [1:0]  m_cost;

    always #10 clk = ~clk;

    regxfer_unit i_regxfer_unit (
        .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .instr_vld_i(vld),
        .obs_sel_i(sel), .obs_data_o(obs), .tos_o(tos), .cost_vld_o(cost_vld),
        .cost_o(cost), .unhandled_o(unh), .stk_err_o(serr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_obs(input int s);
        case (s)
            0:  return 32'h0000FFFF;
            3:  return m_acc;
            7:  return m_prod;
            15: return {16'd0, m_acc[15:0]};
            5:  return {28'd0, 4'(5 - m_lvl)};
            6:  return {16'd0, m_pc};
            default: return {16'd0, m_gr[s]};
        endcase
    endfunction

    function automatic logic [31:0] src_of(input int s);
        case (s)
            0:  return 32'h0000FFFF;
            3:  return m_acc;
            7:  return m_prod;
            15: return {16'd0, m_acc[15:0]};
            5:  return {16'd0, m_stk[m_lvl-1]};
            6:  return {16'd0, m_pc};
            default: return {16'd0, m_gr[s]};
        endcase
    endfunction

    task automatic model_step(input logic [15:0] op);
        int s, d;
        logic wide_s, wide_d;
        logic [31:0] v;
        logic [15:0] n;
        logic pc_loaded;
        s = int'(op[3:0]);
        d = int'(op[7:4]);
        m_cost = 2'd1;
        pc_loaded = 1'b0;
        if (op[15:9] != 7'd0) begin
            m_unh = 1'b1;
        end else if (op != 16'd0) begin
            if (d == 6) m_cost = 2'd2;
            if ((s == 5 && m_lvl == 0) || (d == 5 && s != 5 && m_lvl == 6)) begin
                m_serr = 1'b1;
            end else begin
                wide_s = (s == 3 || s == 7);
                wide_d = (d == 3 || d == 7);
                v = src_of(s);
                n = wide_s ? v[31:16] : v[15:0];
                if (s == 5) m_lvl--;
                case (d)
                    0: ;
                    3: if (wide_s) m_acc = v; else m_acc[31:16] = n;
                    7: if (wide_s) m_prod = v; else m_prod[31:16] = n;
                    15: m_acc[15:0] = n;
                    5: begin m_stk[m_lvl] = n; m_lvl++; end
                    6: begin m_pc = n; pc_loaded = 1'b1; end
                    default: m_gr[d] = n;
                endcase
                if (wide_d) begin end
            end
        end
        if (!pc_loaded) m_pc = m_pc + 16'd1;
    endtask

    task automatic compare_all(input string req);
        for (int k = 0; k < 16; k++) begin
            sel = 4'(k);
            #0.5;
            chk(req, $sformatf("slot %0d", k), obs, exp_obs(k));
        end
        chk(req, "tos", {16'd0, tos}, (m_lvl > 0) ? {16'd0, m_stk[m_lvl-1]} : 32'd0);
        chk(req, "stack error flag", {31'd0, serr}, {31'd0, m_serr});
        chk(req, "unhandled flag", {31'd0, unh}, {31'd0, m_unh});
    endtask

    task automatic exec(input logic [15:0] op, input string req);
        @(negedge clk);
        instr = op;
        vld = 1'b1;
        model_step(op);
        @(negedge clk);
        vld = 1'b0;
        chk(req, "cost valid", {31'd0, cost_vld}, 32'd1);
        chk(req, "cost", {30'd0, cost}, {30'd0, m_cost});
        compare_all(req);
    endtask

    function automatic logic [15:0] mv(input int d, input int s);
        return {8'd0, 4'(d), 4'(s)};
    endfunction

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        for (int k = 0; k < 16; k++) m_gr[k] = 16'd0;
        for (int k = 0; k < 6; k++) m_stk[k] = 16'd0;
        m_acc = 0; m_prod = 0; m_pc = 16'h0400; m_lvl = 0; m_serr = 0; m_unh = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "cost valid at reset", {31'd0, cost_vld}, 32'd0);
        compare_all("R1");

        // R3 16-bit moves, R2 constant
        exec(mv(1, 0), "R2");          // X <- ones
        exec(mv(0, 6), "R2");          // write to constant ignored
        exec(mv(2, 6), "R3");          // Y <- PC
        exec(mv(4, 2), "R3");
        // R5 16 -> 32 upper half
        exec(mv(3, 2), "R5");
        exec(mv(15, 1), "R7");         // low half of acc <- ones
        exec(mv(3, 4), "R5");          // upper rewritten, low kept
        // R4 32 -> 16
        exec(mv(8, 3), "R4");
        exec(mv(9, 15), "R7");         // read low half
        // R6 32 -> 32
        exec(mv(7, 3), "R6");
        exec(mv(10, 7), "R4");
        // R8 nop
        exec(16'h0000, "R8");
        // R9 PC load and cost
        exec(mv(6, 2), "R9");
        exec(mv(11, 6), "R9");
        // R10 stack fill, R11 overflow
        for (int k = 0; k < 6; k++) exec(mv(5, 6), "R10");
        exec(mv(5, 1), "R11");
        exec(mv(5, 5), "R10");         // pop then push, unchanged
        for (int k = 0; k < 6; k++) exec(mv(12, 5), "R10");
        exec(mv(13, 5), "R11");        // underflow
        // R12 non-move opcode
        exec(16'h0200, "R12");
        exec(16'hFE37, "R12");

        // random phase
        for (int it = 0; it < 500; it++) begin
            int r;
            logic [15:0] op;
            r = int'($urandom % 20);
            if (r == 0)      op = {7'(($urandom % 127) + 1), 9'($urandom)};
            else if (r == 1) op = 16'd0;
            else             op = {7'd0, 1'($urandom), 4'($urandom), 4'($urandom)};
            exec(op, "R3");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule